// File: doc/BRIEF.md
# Byte-Gated Data Array with Zero Flags

This block is the data store of a data cache. Each stored word is divided into byte lanes, and every lane keeps one extra flag bit per row. The flag records whether that byte holds only zeros. A write always refreshes the flags. The storage cells of a byte are written only when the incoming byte is nonzero. A read fetches the flags of the selected row together with the row itself. Lanes whose flag is set skip the cell access and return zero. The other lanes return their stored byte.

Requests arrive on a single port that carries a valid, a write enable, an address and write data. Read data comes back registered one cycle after a read request. For every accepted access, in the same cycle as the response, the block reports how many byte lanes skipped the cell access and how many used it. The zero test on write data and the flag lookup on reads run alongside the row access, so no access takes an extra cycle.

Top module: `zgate_data_array`

## Requirements
- R1: For a write, a byte lane (lane i covers write-data bits 8i+7..8i) counts as gated exactly when all eight of its bits are zero.
- R2: A write stores the zero flag of every lane. The storage cells of a lane are written only when that lane's byte is nonzero.
- R3: A read returns, for every lane, the byte most recently written to that address. A lane whose last written byte was zero reads as zero, even if older nonzero data remains in its cells.
- R4: `rsp_valid` is high in the cycle after a read request and low in every other cycle.
- R5: `rd_data` changes only with a read response and otherwise holds its last value.
- R6: One cycle after each access, `stat_valid` is high. For a write, `stat_gated` equals the number of zero bytes in the write data. For a read, it equals the number of stored zero flags in the row. `stat_active` equals the lane count minus `stat_gated`.
- R7: After reset every row reads as zero with all lanes gated. `rsp_valid` and `stat_valid` are low, and `rd_data` is zero.
- R8: A read issued in the cycle right after a write to the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (4) | Row address |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W (32) | Read data |
| stat_valid | output | 1 | Per-access lane counts valid |
| stat_gated | output | CNT_W (3) | Lanes that skipped the cell access |
| stat_active | output | CNT_W (3) | Lanes that accessed their cells |

## Verification
The hardest case to reach from the ports is a lane whose cells still hold an old nonzero byte while its flag says zero. Only the flag stops that stale byte from reaching the output. The stimulus writes dense nonzero words first. It then overwrites the same rows with words that mix zero and nonzero bytes and reads them back. A long random phase draws each byte as zero about half the time over a small address range, so rows are overwritten often and lanes flip between gated and ungated.

// File: rtl/zg_pkg.sv
package zg_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/zg_zero_detect.sv
module zg_zero_detect #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic [LANES*BYTE_W-1:0] data_in,
  output logic [LANES-1:0]        lane_zero
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_zero[g] = (data_in[g*BYTE_W +: BYTE_W] == '0);
  end
endmodule

// File: rtl/zg_popcount.sv
module zg_popcount #(
  parameter int WIDTH = 4,
  parameter int CNT_W = 3
) (
  input  logic [WIDTH-1:0] bits_in,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    count = '0;
    for (int k = 0; k < WIDTH; k++) begin
      count = count + CNT_W'(bits_in[k]);
    end
  end
endmodule

// File: rtl/zg_lane.sv
module zg_lane #(
  parameter int DEPTH  = 16,
  parameter int BYTE_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              flag_we,
  input  logic              flag_wval,
  input  logic              cell_we,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              rd_en,
  output logic              flag_now,
  output logic [BYTE_W-1:0] rbyte
);
  logic [DEPTH-1:0]  flag_q, flag_d;
  logic [BYTE_W-1:0] cell_q [DEPTH];
  logic              zflag_q;
  logic [BYTE_W-1:0] dat_q;
  logic              cell_re;

  assign flag_now = flag_q[addr];
  assign cell_re  = rd_en & ~flag_now;

  always_comb begin
    flag_d = flag_q;
    if (flag_we) flag_d[addr] = flag_wval;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '1;
    else if (flag_we) flag_q <= flag_d;
  end

  always_ff @(posedge clk) begin
    if (cell_we) cell_q[addr] <= wbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     zflag_q <= 1'b1;
    else if (rd_en) zflag_q <= flag_now;
  end

  always_ff @(posedge clk) begin
    if (cell_re) dat_q <= cell_q[addr];
  end

  assign rbyte = zflag_q ? '0 : dat_q;

  // R2: the cells are written only for a nonzero byte
  a_r2_zero_byte_not_written: assert property (@(posedge clk) disable iff (!rst_n)
    cell_we |-> (wbyte != '0));

  // R2: a cell write always comes with a flag write
  a_r2_cell_write_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cell_we |-> (flag_we && !flag_wval));

  // R3: a gated read leaves the data latch untouched
  a_r3_gated_read_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && flag_now) |=> $stable(dat_q));
endmodule

// File: rtl/zgate_data_array.sv
module zgate_data_array #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 16,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              stat_valid,
  output logic [CNT_W-1:0]  stat_gated,
  output logic [CNT_W-1:0]  stat_active
);
  import zg_pkg::*;

  acc_kind_e        kind;
  logic [LANES-1:0] wr_zero;
  logic [LANES-1:0] rd_flag;
  logic [LANES-1:0] gate_vec;
  logic [CNT_W-1:0] gate_cnt;
  logic             rsp_valid_d, stat_valid_d;
  logic [CNT_W-1:0] gated_d, active_d;

  always_comb begin
    if (!req_valid)  kind = ACC_IDLE;
    else if (req_we) kind = ACC_WRITE;
    else             kind = ACC_READ;
  end

  zg_zero_detect #(.LANES(LANES), .BYTE_W(BYTE_W)) i_zdet (
    .data_in  (req_wdata),
    .lane_zero(wr_zero)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    zg_lane #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) i_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (req_addr),
      .flag_we  (kind == ACC_WRITE),
      .flag_wval(wr_zero[g]),
      .cell_we  ((kind == ACC_WRITE) && !wr_zero[g]),
      .wbyte    (req_wdata[g*BYTE_W +: BYTE_W]),
      .rd_en    (kind == ACC_READ),
      .flag_now (rd_flag[g]),
      .rbyte    (rd_data[g*BYTE_W +: BYTE_W])
    );
  end

  assign gate_vec = (kind == ACC_WRITE) ? wr_zero : rd_flag;

  zg_popcount #(.WIDTH(LANES), .CNT_W(CNT_W)) i_pop (
    .bits_in(gate_vec),
    .count  (gate_cnt)
  );

  always_comb begin
    rsp_valid_d  = (kind == ACC_READ);
    stat_valid_d = (kind != ACC_IDLE);
    gated_d      = stat_gated;
    active_d     = stat_active;
    if (kind != ACC_IDLE) begin
      gated_d  = gate_cnt;
      active_d = CNT_W'(LANES) - gate_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      stat_valid  <= 1'b0;
      stat_gated  <= '0;
      stat_active <= '0;
    end else begin
      rsp_valid   <= rsp_valid_d;
      stat_valid  <= stat_valid_d;
      stat_gated  <= gated_d;
      stat_active <= active_d;
    end
  end

  // R4: a read request is answered on the next cycle
  a_r4_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> rsp_valid);

  // R4: no response without a read request
  a_r4_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_we) |=> !rsp_valid);

  // R5: read data holds when no response is given
  a_r5_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_we) |=> $stable(rd_data));

  // R6: the two lane counts always cover every lane
  a_r6_counts_cover_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (32'(stat_gated) + 32'(stat_active) == LANES));

  // R6: an all-zero write gates every lane
  a_r6_zero_write_all_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && req_wdata == '0) |=> (32'(stat_gated) == LANES));
endmodule

// File: tb/test_zgate_data_array.sv
module test_zgate_data_array;
  localparam int PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 16;
  localparam int LANES  = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_we;
  logic [3:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid, stat_valid;
  logic [31:0] rd_data;
  logic [2:0]  stat_gated, stat_active;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] model [DEPTH];
  logic [31:0] exp_rd;

  always #(PERIOD/2) clk = ~clk;

  zgate_data_array i_zgate_data_array (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rd_data(rd_data),
    .stat_valid(stat_valid), .stat_gated(stat_gated), .stat_active(stat_active)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int zero_bytes(input logic [31:0] w);
    int n = 0;
    for (int k = 0; k < LANES; k++) if (w[k*8 +: 8] == 8'h00) n++;
    return n;
  endfunction

  // one request per cycle; outputs compared at the following falling edge
  task automatic step(input bit v, input bit we, input logic [3:0] a, input logic [31:0] d);
    int  gz;
    bit  is_rd;
    req_valid = v; req_we = we; req_addr = a; req_wdata = d;
    is_rd = v && !we;
    gz = 0;
    if (v && we) gz = zero_bytes(d);
    if (is_rd)   begin gz = zero_bytes(model[a]); exp_rd = model[a]; end
    @(posedge clk);
    if (v && we) model[a] = d;
    @(negedge clk);
    check("R4 rsp_valid", 32'(rsp_valid), 32'(is_rd));
    if (is_rd) check("R3/R8 rd_data", rd_data, exp_rd);
    else       check("R5 rd_data hold", rd_data, exp_rd);
    check("R6 stat_valid", 32'(stat_valid), 32'(v));
    if (v) begin
      check("R1/R6 stat_gated", 32'(stat_gated), 32'(gz));
      check("R6 stat_active", 32'(stat_active), 32'(LANES - gz));
    end
  endtask

  function automatic logic [31:0] rnd_word();
    logic [31:0] w;
    for (int k = 0; k < LANES; k++) begin
      w[k*8 +: 8] = ($urandom % 2 == 0) ? 8'h00 : 8'($urandom % 255 + 1);
    end
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    exp_rd = '0;
    rst_n = 1'b0; req_valid = 0; req_we = 0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 rsp_valid", 32'(rsp_valid), 0);
    check("R7 stat_valid", 32'(stat_valid), 0);
    check("R7 rd_data", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: unwritten rows read zero, all lanes gated
    step(1, 0, 4'd5, '0);
    step(1, 0, 4'd15, '0);
    // dense nonzero words, then overwrite with zero-heavy words (R2, R3)
    for (int i = 0; i < DEPTH; i++) step(1, 1, 4'(i), 32'hA5C3_7E11 + 32'(i) * 32'h0101_0101);
    for (int i = 0; i < DEPTH; i++) step(1, 0, 4'(i), '0);
    step(1, 1, 4'd1, 32'h0000_0000);
    step(1, 1, 4'd2, 32'h1200_0034);
    step(1, 1, 4'd3, 32'h00FF_FF00);
    step(1, 1, 4'd4, 32'h0000_0001);
    step(0, 0, 4'd0, '0);
    for (int i = 1; i < 5; i++) step(1, 0, 4'(i), '0);
    // R8: read right after write to the same row
    step(1, 1, 4'd7, 32'h8000_0080);
    step(1, 0, 4'd7, '0);
    step(1, 1, 4'd7, 32'h0000_0000);
    step(1, 0, 4'd7, '0);
    // R5: idle cycles hold the read data
    step(0, 1, 4'd7, 32'hFFFF_FFFF);
    step(0, 0, 4'd3, '0);
    // random mixed traffic over a small address range
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom % 8);
      if (r == 0)      step(0, 0, '0, '0);
      else if (r < 4)  step(1, 1, 4'($urandom % 4), rnd_word());
      else             step(1, 0, 4'($urandom % 4), '0);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule